// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Origin Stack

This block caches virtual-to-physical page translations for several address spaces at once. Each address space is named by the physical origin of its segment table. The full origin is not stored in every buffer entry. A small stack of resident origins hands out a 3-bit identifier per origin, and each buffer entry keeps only that identifier.

A control write loads a new origin to switch address space. The stack is searched first. If the origin is already resident, its identifier becomes current with no stall and no invalidation. If it is not resident, the block takes a slot: an empty slot if one exists, otherwise a round-robin victim that is never the current slot. The block then stalls the load port for one clock. In that clock it invalidates, in parallel, every entry tagged with the chosen slot, and the new origin takes over the slot.

Lookups are combinational from a 32-bit virtual address with a 4 KB page. Fills name an entry index and always write the current identifier. Table walking and protection checks are done outside the block.

Top module: `as_tlb`

## Requirements
- R1: After reset, no address space is current, the load port is ready, and every lookup misses.
- R2: A lookup hits only when an entry is valid, its identifier equals the current one, and its stored page number equals lookup address bits 31:12. On a hit the stored frame number is output. Address bits 11:0 are ignored.
- R3: A fill writes the page number, the frame number and the current identifier into the named entry and marks it valid. A fill made while no address space is current has no effect.
- R4: Loading an origin that is already resident makes it current with no stall. The existing entries of that space hit again.
- R5: Loading an origin that is not resident holds the load port not-ready for exactly the one clock after acceptance.
- R6: While free slots remain, a new origin takes a free slot, and no other space loses entries.
- R7: With all seven slots in use, the victim is chosen round-robin and skips the current slot. Every entry of the evicted space is invalidated, and the entries of the other spaces are kept.
- R8: The same virtual page filled under two address spaces occupies two entries. Each space resolves to its own frame.
- R9: The identifier value 7 is never assigned to a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| org_valid | input | 1 | Origin load request |
| org_data | input | 32 | Segment-table origin to make current |
| org_ready | output | 1 | Load port can accept; low during the flush clock |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | 20 | Frame number of the hitting entry |
| fill_en | input | 1 | Fill strobe |
| fill_idx | input | 7 | Entry index to write |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_pfn | input | 20 | Frame number to store |

## Verification
A corrupted stack shows up on the next origin load. A resident space that stalls the port, or an evicted one that does not, is visible one clock after acceptance. A wrong victim or a wrong flush shows up on the first lookup after that space is reloaded: entries that should have survived miss, or flushed ones still hit. A wrong current identifier shows at once as a lookup that returns another space's frame for a shared page.

// File: rtl/as_tlb.sv
module as_tlb #(
  parameter int ENTRIES = 128,
  parameter int SLOTS   = 7,
  parameter int ORG_W   = 32,
  parameter int VA_W    = 32,
  parameter int PG_SH   = 12,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       org_valid,
  input  logic [ORG_W-1:0]           org_data,
  output logic                       org_ready,
  input  logic [VA_W-1:0]            lk_va,
  output logic                       lk_hit,
  output logic [PFN_W-1:0]           lk_pfn,
  input  logic                       fill_en,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [VA_W-PG_SH-1:0]      fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn
);
  localparam int IW    = $clog2(ENTRIES);
  localparam int VPN_W = VA_W - PG_SH;
  localparam int ID_W  = $clog2(SLOTS + 1);
  localparam logic [ID_W-1:0] NONE = ID_W'(SLOTS);
  localparam logic [ID_W-1:0] LAST = ID_W'(SLOTS - 1);

  logic [ENTRIES-1:0] e_v;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [ID_W-1:0]    e_id  [ENTRIES];

  logic [ORG_W-1:0]   s_org [SLOTS];
  logic [SLOTS-1:0]   s_v;
  logic [ID_W-1:0]    cur, rr, pend_slot;
  logic [ORG_W-1:0]   pend_org;
  logic               busy;

  logic               s_hit, s_free;
  logic [ID_W-1:0]    s_hit_id, free_id, victim;
  logic               accept;

  assign org_ready = !busy;
  assign accept    = org_valid && org_ready;

  always_comb begin
    s_hit = 1'b0; s_hit_id = '0; s_free = 1'b0; free_id = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (s_v[s] && s_org[s] == org_data) begin s_hit = 1'b1; s_hit_id = ID_W'(s); end
      if (!s_v[s]) begin s_free = 1'b1; free_id = ID_W'(s); end
    end
  end

  assign victim = s_free ? free_id :
                  (rr != cur) ? rr : (rr == LAST ? '0 : rr + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_v <= '0; cur <= NONE; rr <= '0; busy <= 1'b0;
      pend_slot <= '0; pend_org <= '0;
    end else if (busy) begin
      busy             <= 1'b0;
      s_v[pend_slot]   <= 1'b1;
      s_org[pend_slot] <= pend_org;
      cur              <= pend_slot;
    end else if (accept) begin
      if (s_hit) cur <= s_hit_id;
      else begin
        busy      <= 1'b1;
        pend_slot <= victim;
        pend_org  <= org_data;
        if (!s_free) rr <= (victim == LAST) ? '0 : victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) e_v <= '0;
    else begin
      if (busy)
        for (int i = 0; i < ENTRIES; i++)
          if (e_id[i] == pend_slot) e_v[i] <= 1'b0;
      if (fill_en && cur != NONE) e_v[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && cur != NONE) begin
      e_vpn[fill_idx] <= fill_vpn;
      e_pfn[fill_idx] <= fill_pfn;
      e_id[fill_idx]  <= cur;
    end
  end

  always_comb begin
    lk_hit = 1'b0; lk_pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (e_v[i] && e_id[i] == cur && e_vpn[i] == lk_va[VA_W-1:PG_SH]) begin
        lk_hit = 1'b1; lk_pfn = e_pfn[i];
      end
  end
endmodule

module as_tlb_chk #(
  parameter int SLOTS = 7,
  parameter int ID_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             org_valid,
  input logic             org_ready,
  input logic             s_hit,
  input logic             s_free,
  input logic             lk_hit,
  input logic [ID_W-1:0]  cur,
  input logic [ID_W-1:0]  victim,
  input logic [SLOTS-1:0] s_v
);
  AST_READY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !org_ready |=> org_ready); // R5
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (org_valid && org_ready && !s_hit) |=> !org_ready); // R5
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (org_valid && org_ready && s_hit) |=> org_ready); // R4
  AST_NO_HIT_WITHOUT_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (cur != ID_W'(SLOTS))); // R1
  AST_VICTIM_NOT_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (org_valid && org_ready && !s_hit && !s_free) |-> (victim != cur)); // R7
  AST_ID7_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (|s_v && org_ready) |-> (cur < ID_W'(SLOTS))); // R9
endmodule

bind as_tlb as_tlb_chk #(.SLOTS(SLOTS), .ID_W(ID_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .org_valid(org_valid), .org_ready(org_ready),
  .s_hit(s_hit), .s_free(s_free), .lk_hit(lk_hit), .cur(cur),
  .victim(victim), .s_v(s_v)
);

// File: tb/test_as_tlb.sv
module test_as_tlb;
  logic clk = 0, rst_n = 0;
  logic org_valid = 0;
  logic [31:0] org_data = 0;
  logic org_ready;
  logic [31:0] lk_va = 0;
  logic lk_hit;
  logic [19:0] lk_pfn;
  logic fill_en = 0;
  logic [6:0] fill_idx = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  as_tlb i_as_tlb (.*);

  function automatic logic [31:0] org(int s); return 32'h0040_0000 + s * 32'h1000; endfunction
  function automatic logic [19:0] pf(int s, int p); return 20'(20'h100 + s * 16 + p); endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic load(int s, bit miss, string r);
    @(negedge clk); org_valid = 1; org_data = org(s);
    @(posedge clk); @(negedge clk); org_valid = 0;
    chk(r, {31'd0, org_ready}, {31'd0, !miss});
    if (miss) begin @(negedge clk); chk("R5", {31'd0, org_ready}, 32'd1); end
  endtask

  task automatic fill(int idx, int vpn, logic [19:0] pfn);
    @(negedge clk); fill_en = 1; fill_idx = 7'(idx); fill_vpn = 20'(vpn); fill_pfn = pfn;
    @(negedge clk); fill_en = 0;
  endtask

  task automatic look(int vpn, bit hit, logic [19:0] pfn, string r);
    lk_va = {20'(vpn), 12'(vpn * 37 + 5)}; #1;
    chk(r, {31'd0, lk_hit}, {31'd0, hit});
    if (hit) chk(r, {12'd0, lk_pfn}, {12'd0, pfn});
  endtask

  initial begin
    #400000; fails++; $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails); $finish;
  end

  initial begin
    repeat (3) @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1", {31'd0, org_ready}, 32'd1);
    look(1, 0, 0, "R1");
    fill(100, 1, 20'hfff);
    // seven new spaces fill free slots
    for (int s = 0; s < 7; s++) begin
      load(s, 1, "R6");
      if (s == 0) look(1, 0, 0, "R3");
      for (int p = 0; p < 4; p++) fill(s * 4 + p, p + 1, pf(s, p));
      look(1, 1, pf(s, 0), "R3");
    end
    // all resident: reload each, shared pages resolve per space
    for (int s = 0; s < 7; s++) begin
      load(s, 0, "R4");
      for (int p = 0; p < 4; p++) look(p + 1, 1, pf(s, p), "R8");
      look(9, 0, 0, "R2");
    end
    // eviction: slot0 (space 0) victim
    load(7, 1, "R7");
    for (int p = 0; p < 4; p++) look(p + 1, 0, 0, "R7");
    load(1, 0, "R4");
    for (int p = 0; p < 4; p++) look(p + 1, 1, pf(1, p), "R7");
    // rr points at current slot -> skips to space 2's slot
    load(0, 1, "R7");
    for (int p = 0; p < 4; p++) look(p + 1, 0, 0, "R7");
    load(1, 0, "R7");
    load(2, 1, "R7");
    look(1, 0, 0, "R7");
    load(4, 0, "R7");
    for (int p = 0; p < 4; p++) look(p + 1, 1, pf(4, p), "R7");
    load(5, 0, "R7");
    load(6, 0, "R7");
    look(2, 1, pf(6, 1), "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule